// File: doc/BRIEF.md
# Decaying Open-Bus Register Latch

This block holds the single data latch that sits behind the memory-mapped register port of a video controller. Every value that crosses the port goes through this latch. A write to any register loads it, and so does a read that actually drives the data lines. When a read only drives some of the lines, the remaining bits are returned from the latch. Each latch bit keeps its own cycle stamp, which records the last time that bit was driven. A bit that has not been refreshed for too long reads back as zero, which models charge leaking off an undriven bus.

The host supplies a free-running 32-bit cycle count, a two-bit register select, read and write strobes and write data. It also supplies the values the surrounding logic would place on the bus: the status byte, the OAM byte, the palette entry, the VRAM read-buffer byte and the upper six bits of the current VRAM address. The block returns the read byte. It also returns three one-cycle pulses: clear vertical blank, reset the two-write toggle, and refill the VRAM read buffer. Rendering, scrolling and the memories themselves stay outside the block.

Top module: `decay_latch_top`

## Requirements
- R1: After synchronous reset, `rd_data` is 0 and all pulse outputs are 0. The latch holds 0 and every bit stamp already counts as stale.
- R2: A write strobe with any select loads `wr_data` into the latch and refreshes all eight bit stamps. A later write-only read returns that byte.
- R3: A status read (select 0) returns `status_in[7:5]` in bits 7:5 and refreshes only those three stamps. Bits 4:0 return the latch bit when the bit's age (count minus stamp) is below 24576, and 0 otherwise.
- R4: A status read raises `vblank_clr` and `toggle_rst` for exactly one cycle, one cycle after the strobe. No other access raises either pulse.
- R5: A VRAM read (select 2) with `vram_page` equal to 6'h3F keeps latch bits 7:6, loads bits 5:0 from `pal_data[5:0]`, refreshes only stamps 5:0 and returns the merged byte.
- R6: A VRAM read with any other page returns `vram_buf`, loads it into the latch, refreshes all stamps, and pulses `buf_refill` one cycle after the strobe.
- R7: A VRAM read whose count is at most 12 cycles after the previous VRAM read returns the latch value from before the access and leaves the latch unchanged. The read time is still recorded, so a chain of close reads all count as fast.
- R8: A write-only read (select 3) returns the latch. It returns 0 when bit 0's age is strictly greater than 24576, so an age of exactly 24576 still returns the latch.
- R9: An OAM read (select 1) returns `oam_data`, loads it into the latch and refreshes all stamps.
- R10: Ages are computed as a 32-bit wrapping difference, so a stamp taken just before the counter wraps stays fresh after the wrap.
- R11: A cycle with both strobes high acts as a write only. No pulse is raised and `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_cnt | input | 32 | Free-running CPU cycle count |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 2 | 0 status, 1 OAM data, 2 VRAM data, 3 write-only register |
| wr_data | input | 8 | Write data |
| status_in | input | 8 | Current status byte (bits 7:5 drive the bus) |
| oam_data | input | 8 | OAM byte at the current OAM address |
| pal_data | input | 8 | Palette entry (bits 5:0 drive the bus) |
| vram_buf | input | 8 | Buffered VRAM byte |
| vram_page | input | 6 | Upper six bits of the 14-bit VRAM address |
| rd_data | output | 8 | Read byte, registered, holds until the next read |
| vblank_clr | output | 1 | One-cycle pulse: clear vertical-blank flag |
| toggle_rst | output | 1 | One-cycle pulse: reset the two-write toggle |
| buf_refill | output | 1 | One-cycle pulse: refill the VRAM buffer from the current address |

## Verification
Every result of an access is registered once. The read byte and all three pulses therefore appear on the edge that samples the strobe and stay valid for the whole following cycle. The monitor sees a strobe at a rising edge and compares 5 ns later, inside that same cycle, against the front item of the expected-value queue. Each stimulus holds its strobe for exactly one edge, so pulses are also checked for the access that should not raise them. Decay and fast-read boundaries are reached by setting the cycle count directly to the limit values (ages of 24575, 24576 and 24577, and read gaps of 12 and 13), not by waiting.

// File: rtl/decay_pkg.sv
package decay_pkg;

    localparam int DATA_W      = 8;
    localparam int CYC_W       = 32;
    localparam int PAGE_W      = 6;
    localparam int DECAY_LIMIT = 24576;
    localparam int FAST_WINDOW = 12;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CYC_W-1:0]  cyc_t;

    // Bits each read source drives onto the bus
    localparam byte_t STATUS_DRIVE = 8'hE0;
    localparam byte_t PAL_DRIVE    = 8'h3F;
    localparam logic [PAGE_W-1:0] PAL_PAGE = 6'h3F;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_OAM    = 2'd1,
        SEL_VRAM   = 2'd2,
        SEL_WONLY  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        byte_t next_latch;
        byte_t refresh;
        byte_t read_val;
        logic  load_read;
        logic  vblank_clr;
        logic  toggle_rst;
        logic  buf_refill;
        logic  vram_rd;
    } bus_step_t;

    function automatic cyc_t age_of(cyc_t now, cyc_t stamp);
        return now - stamp;
    endfunction

    function automatic byte_t drive_merge(byte_t driven, byte_t held, byte_t mask);
        return (driven & mask) | (held & ~mask);
    endfunction

endpackage

// File: rtl/decay_stamp_bank.sv
module decay_stamp_bank
    import decay_pkg::*;
#(
    parameter int NBITS = DATA_W,
    parameter int CW    = CYC_W,
    parameter int LIMIT = DECAY_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    now,
    input  logic [NBITS-1:0] refresh,
    output logic [NBITS-1:0] fresh,
    output logic             lsb_expired
);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] lsb_age;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic [CW-1:0] stamp;
        logic [CW-1:0] age;

        always_ff @(posedge clk) begin
            if (rst)             stamp <= now - LIMIT_C;
            else if (refresh[i]) stamp <= now;
        end

        assign age      = now - stamp;
        assign fresh[i] = age < LIMIT_C;
    end

    assign lsb_age     = g_bit[0].age;
    assign lsb_expired = lsb_age > LIMIT_C;

endmodule

// File: rtl/decay_fast_detect.sv
module decay_fast_detect
    import decay_pkg::*;
#(
    parameter int CW     = CYC_W,
    parameter int WINDOW = FAST_WINDOW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] now,
    input  logic          record,
    output logic          fast
);
    localparam logic [CW-1:0] WINDOW_C = CW'(WINDOW);

    logic [CW-1:0] last_rd;

    always_ff @(posedge clk) begin
        if (rst)         last_rd <= now - WINDOW_C - CW'(1);
        else if (record) last_rd <= now;
    end

    assign fast = age_of(now, last_rd) <= WINDOW_C;

endmodule

// File: rtl/decay_access_ctl.sv
module decay_access_ctl
    import decay_pkg::*;
(
    input  logic              rd_en,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  byte_t             wr_data,
    input  byte_t             status_in,
    input  byte_t             oam_data,
    input  byte_t             pal_data,
    input  byte_t             vram_buf,
    input  logic [PAGE_W-1:0] vram_page,
    input  byte_t             latch_q,
    input  byte_t             fresh,
    input  logic              lsb_expired,
    input  logic              fast,
    output bus_step_t         step
);
    logic  pal_hit;
    byte_t vram_val;

    assign pal_hit  = vram_page == PAL_PAGE;
    assign vram_val = pal_hit ? drive_merge(pal_data, latch_q, PAL_DRIVE) : vram_buf;

    always_comb begin
        step            = '0;
        step.next_latch = latch_q;
        if (wr_en) begin
            step.next_latch = wr_data;
            step.refresh    = '1;
        end else if (rd_en) begin
            step.load_read = 1'b1;
            case (sel)
                SEL_STATUS: begin
                    step.next_latch = drive_merge(status_in, latch_q, STATUS_DRIVE);
                    step.refresh    = STATUS_DRIVE;
                    step.read_val   = drive_merge(status_in, latch_q & fresh, STATUS_DRIVE);
                    step.vblank_clr = 1'b1;
                    step.toggle_rst = 1'b1;
                end
                SEL_OAM: begin
                    step.next_latch = oam_data;
                    step.refresh    = '1;
                    step.read_val   = oam_data;
                end
                SEL_VRAM: begin
                    step.vram_rd    = 1'b1;
                    step.buf_refill = !pal_hit;
                    step.refresh    = pal_hit ? PAL_DRIVE : '1;
                    step.next_latch = fast ? latch_q : vram_val;
                    step.read_val   = fast ? latch_q : vram_val;
                end
                default: begin
                    step.read_val = lsb_expired ? '0 : latch_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/decay_latch_top.sv
module decay_latch_top
    import decay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CYC_W-1:0]  cyc_cnt,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] oam_data,
    input  logic [DATA_W-1:0] pal_data,
    input  logic [DATA_W-1:0] vram_buf,
    input  logic [PAGE_W-1:0] vram_page,
    output logic [DATA_W-1:0] rd_data,
    output logic              vblank_clr,
    output logic              toggle_rst,
    output logic              buf_refill
);
    byte_t     latch_q;
    byte_t     rd_q;
    byte_t     bit_fresh;
    logic      lsb_stale;
    logic      rd_fast;
    logic      vclr_q, trst_q, refill_q;
    bus_step_t step;

    decay_stamp_bank #(
        .NBITS(DATA_W), .CW(CYC_W), .LIMIT(DECAY_LIMIT)
    ) u_stamps (
        .clk         (clk),
        .rst         (rst),
        .now         (cyc_cnt),
        .refresh     (step.refresh),
        .fresh       (bit_fresh),
        .lsb_expired (lsb_stale)
    );

    decay_fast_detect #(
        .CW(CYC_W), .WINDOW(FAST_WINDOW)
    ) u_fast (
        .clk    (clk),
        .rst    (rst),
        .now    (cyc_cnt),
        .record (step.vram_rd),
        .fast   (rd_fast)
    );

    decay_access_ctl u_ctl (
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .sel         (reg_sel_e'(reg_sel)),
        .wr_data     (wr_data),
        .status_in   (status_in),
        .oam_data    (oam_data),
        .pal_data    (pal_data),
        .vram_buf    (vram_buf),
        .vram_page   (vram_page),
        .latch_q     (latch_q),
        .fresh       (bit_fresh),
        .lsb_expired (lsb_stale),
        .fast        (rd_fast),
        .step        (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            rd_q     <= '0;
            vclr_q   <= 1'b0;
            trst_q   <= 1'b0;
            refill_q <= 1'b0;
        end else begin
            latch_q  <= step.next_latch;
            if (step.load_read) rd_q <= step.read_val;
            vclr_q   <= step.vblank_clr;
            trst_q   <= step.toggle_rst;
            refill_q <= step.buf_refill;
        end
    end

    assign rd_data    = rd_q;
    assign vblank_clr = vclr_q;
    assign toggle_rst = trst_q;
    assign buf_refill = refill_q;

endmodule

// File: rtl/decay_latch_chk.sv
module decay_latch_chk
    import decay_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] oam_data,
    input logic [PAGE_W-1:0] vram_page,
    input logic [DATA_W-1:0] rd_data,
    input logic              vblank_clr,
    input logic              toggle_rst,
    input logic              buf_refill,
    input logic [DATA_W-1:0] latch_q,
    input logic              fast
);
    logic rd_only;
    assign rd_only = rd_en && !wr_en;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> latch_q == $past(wr_data));

    // R4
    status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_only && reg_sel == SEL_STATUS) |=> (vblank_clr && toggle_rst));

    // R4
    no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_only && reg_sel == SEL_STATUS) |=> (!vblank_clr && !toggle_rst));

    // R6
    refill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_only && reg_sel == SEL_VRAM && vram_page != PAL_PAGE) |=> buf_refill);

    // R9
    oam_load_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_only && reg_sel == SEL_OAM) |=> (rd_data == $past(oam_data) && latch_q == $past(oam_data)));

    // R7
    fast_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_only && reg_sel == SEL_VRAM && fast) |=> ($stable(latch_q) && rd_data == latch_q));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> ($stable(rd_data) && !buf_refill && !vblank_clr));

endmodule

bind decay_latch_top decay_latch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .oam_data   (oam_data),
    .vram_page  (vram_page),
    .rd_data    (rd_data),
    .vblank_clr (vblank_clr),
    .toggle_rst (toggle_rst),
    .buf_refill (buf_refill),
    .latch_q    (latch_q),
    .fast       (rd_fast)
);

// File: tb/sim_decay_latch_top.sv
`timescale 1ns/1ps
module sim_decay_latch_top;
    import decay_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cyc_cnt = 32'd1000;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  wr_data = 8'h00, status_in = 8'h00, oam_data = 8'h00;
    logic [7:0]  pal_data = 8'h00, vram_buf = 8'h00;
    logic [5:0]  vram_page = 6'h00;
    logic [7:0]  rd_data;
    logic        vblank_clr, toggle_rst, buf_refill;

    always #10 clk = ~clk;

    decay_latch_top u0 (
        .clk(clk), .rst(rst), .cyc_cnt(cyc_cnt), .rd_en(rd_en), .wr_en(wr_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .status_in(status_in),
        .oam_data(oam_data), .pal_data(pal_data), .vram_buf(vram_buf),
        .vram_page(vram_page), .rd_data(rd_data), .vblank_clr(vblank_clr),
        .toggle_rst(toggle_rst), .buf_refill(buf_refill)
    );

    typedef struct {
        logic [7:0] data;
        logic       vclr;
        logic       trst;
        logic       refill;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_checks = 0;
    int   n_err    = 0;
    bit   done     = 0;

    // Reference model state
    logic [7:0]  m_latch, m_rd;
    logic [31:0] m_ts [8];
    logic [31:0] m_last;

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual data/vclr/trst/refill=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_latch = 8'h00;
        m_rd    = 8'h00;
        for (int i = 0; i < 8; i++) m_ts[i] = 32'd1000 - 32'd24576;
        m_last  = 32'd1000 - 32'd13;
    endtask

    task automatic op(input logic [31:0] t, input logic r, input logic w,
                      input reg_sel_e s, input logic [7:0] d, input string tag);
        exp_t x;
        logic [7:0] val;
        @(posedge clk); #2;
        cyc_cnt = t; rd_en = r; wr_en = w; reg_sel = s; wr_data = d;
        x.vclr = 0; x.trst = 0; x.refill = 0; x.tag = tag;
        if (w) begin
            m_latch = d;
            for (int i = 0; i < 8; i++) m_ts[i] = t;
        end else if (s == SEL_STATUS) begin
            val = {status_in[7:5], 5'b0};
            for (int i = 0; i < 5; i++)
                if (t - m_ts[i] < 32'd24576) val[i] = m_latch[i];
            m_latch = {status_in[7:5], m_latch[4:0]};
            for (int i = 5; i < 8; i++) m_ts[i] = t;
            m_rd = val; x.vclr = 1; x.trst = 1;
        end else if (s == SEL_OAM) begin
            m_latch = oam_data; m_rd = oam_data;
            for (int i = 0; i < 8; i++) m_ts[i] = t;
        end else if (s == SEL_VRAM) begin
            if (vram_page == 6'h3F) begin
                val = {m_latch[7:6], pal_data[5:0]};
                for (int i = 0; i < 6; i++) m_ts[i] = t;
            end else begin
                val = vram_buf; x.refill = 1;
                for (int i = 0; i < 8; i++) m_ts[i] = t;
            end
            if (t - m_last > 32'd12) m_latch = val;
            m_rd = m_latch;
            m_last = t;
        end else begin
            m_rd = (t - m_ts[0] > 32'd24576) ? 8'h00 : m_latch;
        end
        x.data = m_rd;
        q.push_back(x);
        @(posedge clk); #2;
        rd_en = 0; wr_en = 0;
    endtask

    // Monitor: result is due on the edge that samples the strobe
    always @(posedge clk) begin
        if (!rst && (rd_en || wr_en)) begin
            #5;
            if (q.size() == 0) begin
                n_checks++; n_err++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                e = q.pop_front();
                check(e.tag, {rd_data, vblank_clr, toggle_rst, buf_refill},
                             {e.data, e.vclr, e.trst, e.refill});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 0;
        #5;
        // R1 reset state
        check("R1", {rd_data, vblank_clr, toggle_rst, buf_refill}, 11'd0);
        op(32'd1001, 1, 0, SEL_WONLY, 8'h00, "R1");

        // R2 write then write-only read
        op(32'd2000, 0, 1, SEL_WONLY, 8'hA5, "R2");
        op(32'd2001, 1, 0, SEL_WONLY, 8'h00, "R2");

        // R3/R4 status reads across the decay boundary
        status_in = 8'h9F;
        op(32'd2002, 1, 0, SEL_STATUS, 8'h00, "R4");
        status_in = 8'h40;
        op(32'd2000 + 32'd24575, 1, 0, SEL_STATUS, 8'h00, "R3");
        status_in = 8'h00;
        op(32'd2000 + 32'd24576, 1, 0, SEL_STATUS, 8'h00, "R3");

        // R8 write-only boundary: age 24576 keeps, 24577 clears
        op(32'd2000 + 32'd24576, 1, 0, SEL_WONLY, 8'h00, "R8");
        op(32'd2000 + 32'd24577, 1, 0, SEL_WONLY, 8'h00, "R8");

        // R9 OAM read
        oam_data = 8'h3C;
        op(32'd30000, 1, 0, SEL_OAM, 8'h00, "R9");
        op(32'd30001, 1, 0, SEL_WONLY, 8'h00, "R9");

        // R6 non-palette VRAM read
        vram_page = 6'h01; vram_buf = 8'h77;
        op(32'd31000, 1, 0, SEL_VRAM, 8'h00, "R6");
        // R5 palette read
        vram_page = 6'h3F; pal_data = 8'hEA;
        op(32'd31100, 1, 0, SEL_VRAM, 8'h00, "R5");
        // R7 fast reads: gaps 8, 12, then 13
        vram_page = 6'h02; vram_buf = 8'h11;
        op(32'd31108, 1, 0, SEL_VRAM, 8'h00, "R7");
        vram_buf = 8'h22;
        op(32'd31120, 1, 0, SEL_VRAM, 8'h00, "R7");
        vram_buf = 8'h33;
        op(32'd31133, 1, 0, SEL_VRAM, 8'h00, "R7");

        // R5 partial refresh: bits 5:0 stay fresh after bits 7:6 age out
        op(32'd40000, 0, 1, SEL_OAM, 8'hFF, "R2");
        vram_page = 6'h3F; pal_data = 8'h15;
        op(32'd60000, 1, 0, SEL_VRAM, 8'h00, "R5");
        status_in = 8'h00;
        op(32'd64576, 1, 0, SEL_STATUS, 8'h00, "R5");
        op(32'd64577, 1, 0, SEL_WONLY, 8'h00, "R5");

        // R10 counter wrap keeps stamps fresh
        op(32'hFFFF_FFF0, 0, 1, SEL_VRAM, 8'h5A, "R10");
        status_in = 8'h20;
        op(32'h0000_0010, 1, 0, SEL_STATUS, 8'h00, "R10");
        op(32'h0000_0011, 1, 0, SEL_WONLY, 8'h00, "R10");

        // R11 both strobes: write only
        op(32'h0000_0020, 1, 1, SEL_STATUS, 8'hC3, "R11");
        op(32'h0000_0021, 1, 0, SEL_WONLY, 8'h00, "R11");

        repeat (3) @(posedge clk);
        n_checks++;
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule